// File: doc/BRIEF.md
# Saturating SIMD Pack Unit

This block narrows packed integer data. It joins a 64-bit destination operand and a 64-bit source operand into one 128-bit value, with the source in the upper half. It splits that value into equal elements and shrinks each element to half its width. A value that does not fit in the narrower field is clamped to the nearest bound. The narrowed elements are packed side by side into a single 64-bit result. A 2-bit mode selects one of three conversions:

- 32-bit to 16-bit, signed
- 16-bit to 8-bit, signed
- 16-bit to 8-bit, unsigned

The narrowing datapath is combinational. By default it is followed by one output register. The register loads when `in_valid` is high, and `out_valid` reports the new result one cycle later. With `OUT_REG = 0` the register is left out, and the result and flag follow the inputs in the same cycle. The fourth mode encoding is not a conversion. In that mode the destination operand passes through unchanged and an illegal-mode flag is raised.

Top module: `simd_pack_unit`

## Requirements
- R1: The intermediate value is {src, dst}, so dst occupies bits 63:0 and src bits 127:64. Result element i comes from intermediate element i, which places the dst-derived elements in the low half of `result`.
- R2: In mode 2'b00, the intermediate value is read as four signed 32-bit elements. Each is narrowed to a signed 16-bit field, and element i lands in result[16i+15:16i].
- R3: In modes 2'b01 and 2'b10, the intermediate value is read as eight 16-bit elements. Each is narrowed to an 8-bit field, and element i lands in result[8i+7:8i].
- R4: In the signed modes, an element above the signed target maximum becomes 16'h7FFF (mode 00) or 8'h7F (mode 01).
- R5: In the signed modes, an element below the signed target minimum becomes 16'h8000 (mode 00) or 8'h80 (mode 01).
- R6: In mode 2'b10, each 16-bit element is read as signed. A negative element becomes 8'h00, and an element above 255 becomes 8'hFF.
- R7: An element whose value already fits the target range is passed through as its low bits, unchanged.
- R8: In mode 2'b11, `result` equals dst and `illegal_mode` is 1. In every other mode `illegal_mode` is 0.
- R9: With the default registered output, `out_valid` rises exactly one cycle after `in_valid`. `result` and `illegal_mode` change only on a cycle in which `in_valid` is high, and otherwise hold their value.
- R10: After a synchronous active-low reset, `out_valid`, `result` and `illegal_mode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | 00 dword→word signed, 01 word→byte signed, 10 word→byte unsigned, 11 illegal |
| dst | input | 64 | Destination operand (low half of intermediate) |
| src | input | 64 | Source operand (high half of intermediate) |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Packed narrowed result |
| illegal_mode | output | 1 | Last accepted mode was the unused encoding |

## Verification
Clamping up, clamping down and exact pass-through can all happen in the same cycle, in neighbouring lanes of one result word. The bench provokes this with a rotating pattern of boundary values such as 0x7FFF, 0x8000, 0x0100, 0xFFFF and 0x007F, placed so that every lane position meets every boundary value across the sweep. Each lane is judged against an arithmetic reference computed in the bench. Random operands in every mode supplement the boundary sweep.

// File: rtl/simd_pack_pkg.sv
// Shared definitions for the saturating pack unit.
// Assumes a 2-bit mode field whose fourth encoding is reserved.
package simd_pack_pkg;
    typedef enum logic [1:0] {
        NARROW_D2W_S = 2'b00,
        NARROW_W2B_S = 2'b01,
        NARROW_W2B_U = 2'b10,
        NARROW_BAD   = 2'b11
    } narrow_mode_e;
endpackage

// File: rtl/sat_narrow_lane.sv
// One narrowing lane: reduces an IN_W-bit element to IN_W/2 bits with
// signed or unsigned saturation. Assumes IN_W is even and at least 4.
// In unsigned mode the input is still read as signed, so negative values
// clamp to zero.
module sat_narrow_lane #(
    parameter int IN_W = 16
) (
    input  logic [IN_W-1:0]   din,
    input  logic              unsigned_mode,
    output logic [IN_W/2-1:0] dout
);
    localparam int OUT_W = IN_W / 2;

    logic neg;
    logic fits_s;
    logic fits_u;

    // Range detection: sign and whether the upper bits are redundant.
    always_comb begin
        neg    = din[IN_W-1];
        fits_s = (din[IN_W-1:OUT_W-1] == {(OUT_W+1){1'b0}}) ||
                 (din[IN_W-1:OUT_W-1] == {(OUT_W+1){1'b1}});
        fits_u = (din[IN_W-1:OUT_W] == {OUT_W{1'b0}});
    end

    // Clamp selection per saturation kind.
    always_comb begin
        if (unsigned_mode) begin
            if (neg)          dout = {OUT_W{1'b0}};
            else if (!fits_u) dout = {OUT_W{1'b1}};
            else              dout = din[OUT_W-1:0];
        end else begin
            if (fits_s)       dout = din[OUT_W-1:0];
            else if (neg)     dout = {1'b1, {(OUT_W-1){1'b0}}};
            else              dout = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end

    // Lane-level checks.
    always_comb begin
        // R4 / R5: signed narrowing never flips the sign of an element.
        a_r4_sign_kept: assert (unsigned_mode || (dout[OUT_W-1] == din[IN_W-1]));
        // R6: an unsigned-mode output never carries a value from a negative input.
        a_r6_neg_clamps_zero: assert (!unsigned_mode || !din[IN_W-1] || (dout == '0));
        // R7: an unsigned-mode value inside the range keeps its numeric value.
        a_r7_fit_unchanged: assert (!unsigned_mode || (din > IN_W'(dout)) || (IN_W'(dout) == din));
    end
endmodule

// File: rtl/simd_pack_core.sv
// Combinational pack datapath: joins {src, dst}, narrows every element
// in all three modes in parallel and selects the result by mode.
// Assumes DATA_W is a multiple of 32.
module simd_pack_core
    import simd_pack_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] packed_res,
    output logic              bad_mode
);
    localparam int WIDE_W = 2 * DATA_W;
    localparam int DW_W   = 32;
    localparam int W_W    = 16;
    localparam int N_DW   = WIDE_W / DW_W;
    localparam int N_W    = WIDE_W / W_W;

    logic [WIDE_W-1:0] wide;
    logic [DATA_W-1:0] d2w_res;
    logic [DATA_W-1:0] w2b_res;
    logic              w2b_unsigned;

    // Intermediate value: source forms the upper half.
    always_comb begin
        wide         = {src, dst};
        w2b_unsigned = (mode == NARROW_W2B_U);
    end

    // Doubleword-to-word lanes.
    for (genvar g = 0; g < N_DW; g++) begin : g_d2w
        sat_narrow_lane #(.IN_W(DW_W)) u_lane (
            .din          (wide[g*DW_W +: DW_W]),
            .unsigned_mode(1'b0),
            .dout         (d2w_res[g*(DW_W/2) +: DW_W/2])
        );
    end

    // Word-to-byte lanes, shared by the signed and unsigned modes.
    for (genvar g = 0; g < N_W; g++) begin : g_w2b
        sat_narrow_lane #(.IN_W(W_W)) u_lane (
            .din          (wide[g*W_W +: W_W]),
            .unsigned_mode(w2b_unsigned),
            .dout         (w2b_res[g*(W_W/2) +: W_W/2])
        );
    end

    // Mode select, with pass-through for the reserved encoding.
    always_comb begin
        bad_mode = 1'b0;
        unique case (mode)
            NARROW_D2W_S: packed_res = d2w_res;
            NARROW_W2B_S,
            NARROW_W2B_U: packed_res = w2b_res;
            default: begin
                packed_res = dst;
                bad_mode   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/simd_pack_unit.sv
// Top of the saturating pack unit. Wraps the combinational core with an
// optional output register (OUT_REG = 1) loaded on in_valid. Assumes
// in_valid carries no backpressure: every accepted operand pair produces
// a result one cycle later.
module simd_pack_unit
    import simd_pack_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] src,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal_mode
);
    logic [DATA_W-1:0] core_res;
    logic              core_bad;

    simd_pack_core #(.DATA_W(DATA_W)) u_core (
        .mode      (mode),
        .dst       (dst),
        .src       (src),
        .packed_res(core_res),
        .bad_mode  (core_bad)
    );

    if (OUT_REG) begin : g_reg
        logic              vld_q;
        logic [DATA_W-1:0] res_q;
        logic              bad_q;

        // Output stage: capture on accepted input, hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                res_q <= '0;
                bad_q <= 1'b0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) begin
                    res_q <= core_res;
                    bad_q <= core_bad;
                end
            end
        end

        assign out_valid    = vld_q;
        assign result       = res_q;
        assign illegal_mode = bad_q;

        // R9: valid travels through exactly one stage.
        a_r9_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        a_r9_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R9: no input accepted means the outputs hold.
        a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(result) && $stable(illegal_mode)));
        // R8: the reserved encoding returns dst and raises the flag.
        a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode == NARROW_BAD) |=> (illegal_mode && result == $past(dst)));
        // R8: legal encodings clear the flag.
        a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode != NARROW_BAD) |=> !illegal_mode);
    end else begin : g_comb
        assign out_valid    = in_valid;
        assign result       = core_res;
        assign illegal_mode = core_bad;
    end
endmodule

// File: tb/simd_pack_unit_tb.sv
module simd_pack_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [63:0] dst = '0;
    logic [63:0] src = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_pack_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .dst(dst), .src(src), .out_valid(out_valid), .result(result),
        .illegal_mode(illegal_mode)
    );

    // Arithmetic reference for every mode.
    function automatic logic [63:0] ref_pack(input logic [1:0] m, input logic [63:0] d,
                                             input logic [63:0] s);
        logic [127:0] w;
        logic [63:0]  r;
        w = {s, d};
        r = d;
        if (m == 2'b00) begin
            for (int k = 0; k < 4; k++) begin
                longint v;
                v = longint'($signed(w[32*k +: 32]));
                if (v > 32767)       r[16*k +: 16] = 16'h7FFF;
                else if (v < -32768) r[16*k +: 16] = 16'h8000;
                else                 r[16*k +: 16] = 16'(v);
            end
        end else if (m != 2'b11) begin
            for (int k = 0; k < 8; k++) begin
                int v;
                v = int'($signed(w[16*k +: 16]));
                if (m == 2'b01) begin
                    if (v > 127)       r[8*k +: 8] = 8'h7F;
                    else if (v < -128) r[8*k +: 8] = 8'h80;
                    else               r[8*k +: 8] = 8'(v);
                end else begin
                    if (v < 0)         r[8*k +: 8] = 8'h00;
                    else if (v > 255)  r[8*k +: 8] = 8'hFF;
                    else               r[8*k +: 8] = 8'(v);
                end
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one operand pair at a falling edge, check one cycle later.
    task automatic apply(input string req, input logic [1:0] m, input logic [63:0] d,
                         input logic [63:0] s);
        @(negedge clk);
        in_valid = 1'b1; mode = m; dst = d; src = s;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " value"}, result, ref_pack(m, d, s));
        check({req, " valid"}, {63'b0, out_valid}, 64'd1);
        check("R8 flag", {63'b0, illegal_mode}, {63'b0, (m == 2'b11)});
    endtask

    logic [15:0] wb [12] = '{16'h0000, 16'h0001, 16'h007F, 16'h0080, 16'h00FF, 16'h0100,
                             16'h7FFF, 16'h8000, 16'hFF80, 16'hFF7F, 16'hFFFF, 16'hFF00};
    logic [31:0] db [10] = '{32'h0000_0000, 32'h0000_7FFF, 32'h0000_8000, 32'hFFFF_8000,
                             32'hFFFF_7FFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                             32'h0001_0000, 32'hFFFF_FFFE};

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state.
        check("R10 result", result, 64'd0);
        check("R10 valid", {63'b0, out_valid}, 64'd0);
        check("R10 flag", {63'b0, illegal_mode}, 64'd0);
        rst_n = 1'b1;

        // R1: ordering, dst elements in the low half.
        apply("R1", 2'b01, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005);
        check("R1 order", result, 64'h0807_0605_0403_0201);
        // R4 / R5 / R7: directed clamps.
        apply("R4", 2'b00, 64'h0000_0000_0001_0000, 64'h0);
        check("R4 d2w high", result, 64'h0000_0000_0000_7FFF);
        apply("R5", 2'b01, 64'h0000_0000_0000_FF00, 64'h0);
        check("R5 w2b low", result, 64'h0000_0000_0000_0080);
        apply("R7", 2'b00, 64'hFFFF_FFFF_0000_1234, 64'h0);
        check("R7 fits", result, 64'h0000_0000_FFFF_1234);
        // R6: unsigned clamps.
        apply("R6", 2'b10, 64'h0000_00FF_0100_FFFF, 64'h0);
        check("R6 unsigned", result, 64'h0000_0000_00FF_FF00);
        // R8: reserved encoding.
        apply("R8", 2'b11, 64'hDEAD_BEEF_0123_4567, 64'hFFFF_0000_FFFF_0000);
        check("R8 passthru", result, 64'hDEAD_BEEF_0123_4567);

        // R3 / R4 / R5 / R6 / R7: rotating word boundary sweep.
        for (int i = 0; i < 12; i++) begin
            logic [127:0] w;
            for (int k = 0; k < 8; k++) w[16*k +: 16] = wb[(i + k) % 12];
            apply("R3 signed sweep", 2'b01, w[63:0], w[127:64]);
            apply("R6 unsigned sweep", 2'b10, w[63:0], w[127:64]);
        end
        // R2 / R4 / R5 / R7: rotating doubleword boundary sweep.
        for (int i = 0; i < 10; i++) begin
            logic [127:0] w;
            for (int k = 0; k < 4; k++) w[32*k +: 32] = db[(i + k) % 10];
            apply("R2 sweep", 2'b00, w[63:0], w[127:64]);
        end
        // Random operands in every mode.
        for (int i = 0; i < 400; i++) begin
            logic [63:0] rd, rs;
            rd = {$urandom, $urandom};
            rs = {$urandom, $urandom};
            apply("R2/R3 random", 2'(i % 4), rd, rs);
        end

        // R9: idle cycle with changed inputs holds result, drops valid.
        apply("R9 setup", 2'b00, 64'h0000_0005_0000_0006, 64'h0);
        @(negedge clk);
        mode = 2'b11; dst = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        check("R9 hold", result, 64'h0000_0000_0005_0006);
        check("R9 valid low", {63'b0, out_valid}, 64'd0);
        check("R9 flag hold", {63'b0, illegal_mode}, 64'd0);
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule